// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Dispatcher

This block sits between a set of physical devices and several emulated processor contexts that share one host. Its lower stage reacts at once to a device request. It records the device as pending, acknowledges the request in the next cycle and marks the owning context as having a logical interrupt. Every device carries a programmable owner context, a bus-request priority and a trap vector address. Each context therefore sees its own pending set, ranked by priority.

The upper stage runs only when the active context reports an instruction boundary. If a console command is waiting, that takes precedence. Otherwise the highest-ranked pending device of the active context is compared with the current CPU priority. A strictly higher device priority produces a state-change request that carries the device's vector, and the device leaves the queue. In every other case the context simply resumes. Devices owned by an idle context stay pending until that context runs. A per-context wait indicator and a per-context device re-initialisation request complete the block.

Top module: `irq_dispatch`

## Requirements
- R1: A device whose request input is high while it is not pending becomes pending at the next clock edge. At that edge `irq_ack` for that device goes high for exactly one cycle, and bit c of `logical_flag` becomes 1, where c is the device's owner.
- R2: While a device is already pending, its held request causes no further acknowledge and no second queue entry.
- R3: Within a context the head is the pending device with the numerically largest priority. Among equal priorities the device captured earlier comes first. Devices captured in the same cycle are ordered by lower device index first.
- R4: The service outputs `svc_trap`, `svc_cmd` and `svc_resume` are registered. In the cycle after `boundary` is high, exactly one of them is high. In the cycle after `boundary` is low, all three are low.
- R5: A trap is issued only when the active context has a logical interrupt and `cpu_prio` is strictly less than the head's priority. `svc_vec` then equals the head device's vector. When the head's priority is equal or lower, the outcome is resume and the queue is unchanged.
- R6: A trap removes the head device from the queue. `logical_flag` for a context is 1 exactly while that context has at least one pending device.
- R7: If `cmd_pending` is high at a boundary where the active context has a logical interrupt, the outcome is `svc_cmd` and the queue is left unchanged.
- R8: Requests from devices owned by a context other than `act_ctx` stay pending. Boundaries of other contexts do not disturb them, and they are serviced when their owner becomes active.
- R9: `wait_req` sets bit `act_ctx` of `wait_flag`. That bit clears when a device owned by that context is captured. A capture for another context leaves it set.
- R10: `ctx_reset_req` makes `dev_init` pulse for one cycle on exactly the devices owned by `act_ctx`, and it clears their pending state. A boundary in the same cycle produces no service outcome.
- R11: A configuration write (`cfg_we`) sets the owner, priority and vector of device `cfg_dev`. A pending device whose owner is rewritten moves to the new owner's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for the device attribute table |
| cfg_dev | input | DEV_W | Device index being written |
| cfg_owner | input | CTX_W | New owner context |
| cfg_prio | input | PRIO_W | New bus-request priority (larger is more urgent) |
| cfg_vec | input | VEC_W | New trap vector address |
| irq_req | input | NUM_DEV | Physical interrupt request, one bit per device, held until acknowledged |
| irq_ack | output | NUM_DEV | One-cycle acknowledge dismissing the physical request |
| act_ctx | input | CTX_W | Context currently running |
| boundary | input | 1 | Active context is at an instruction fetch boundary |
| cpu_prio | input | PRIO_W | Current CPU priority of the active context |
| cmd_pending | input | 1 | Console command waiting for the active context |
| wait_req | input | 1 | Active context executed a wait instruction |
| ctx_reset_req | input | 1 | Active context requests re-initialisation of its devices |
| logical_flag | output | NUM_CTX | Per-context logical interrupt indicator |
| wait_flag | output | NUM_CTX | Per-context wait indicator |
| svc_trap | output | 1 | State-change request |
| svc_vec | output | VEC_W | Vector of the trapped device |
| svc_cmd | output | 1 | Console command handler must run |
| svc_resume | output | 1 | Resume at the point of interruption |
| dev_init | output | NUM_DEV | One-cycle re-initialisation pulse per device |

## Verification
The bench builds the dispatcher with six devices, three contexts, three priority bits and nine vector bits. A non-power-of-two context count leaves one encoding of `act_ctx` unused, and three contexts let one context be idle while two others trade service. Six devices are enough for two same-priority devices in one context together with a higher-priority device, for devices split across contexts, and for simultaneous captures. All of the ordering, ownership-move and reset-scope cases can therefore be reached in a few hundred cycles.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  // Ranking rule shared by the head selector: a beats b on higher priority,
  // or on equal priority when a was captured earlier.
  function automatic logic ranks_above(input logic [7:0] pa, input logic [7:0] pb,
                                       input logic a_older);
    return (pa > pb) || ((pa == pb) && a_older);
  endfunction

  // Strict comparison deciding whether a queued device may preempt the CPU.
  function automatic logic may_preempt(input logic [7:0] cpu, input logic [7:0] dev);
    return cpu < dev;
  endfunction
endpackage

// File: rtl/irqd_dev_table.sv
module irqd_dev_table #(
  parameter int NUM_DEV = 8,
  parameter int DEV_W   = 3,
  parameter int CTX_W   = 1,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [DEV_W-1:0]                  dev,
  input  logic [CTX_W-1:0]                  owner_in,
  input  logic [PRIO_W-1:0]                 prio_in,
  input  logic [VEC_W-1:0]                  vec_in,
  output logic [NUM_DEV-1:0][CTX_W-1:0]     owner,
  output logic [NUM_DEV-1:0][PRIO_W-1:0]    prio,
  output logic [NUM_DEV-1:0][VEC_W-1:0]     vec
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        owner[i] <= '0;
        prio[i]  <= '0;
        vec[i]   <= '0;
      end else if (we && (dev == DEV_W'(i))) begin
        owner[i] <= owner_in;
        prio[i]  <= prio_in;
        vec[i]   <= vec_in;
      end
    end
  end
endmodule

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int NUM_DEV = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_DEV-1:0]               irq_req,
  input  logic [NUM_DEV-1:0]               clr,
  output logic [NUM_DEV-1:0]               cap,
  output logic [NUM_DEV-1:0]               pend,
  output logic [NUM_DEV-1:0]               ack,
  output logic [NUM_DEV-1:0][NUM_DEV-1:0]  older
);
  assign cap = irq_req & ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ack  <= '0;
    end else begin
      pend <= (pend | cap) & ~clr;
      ack  <= cap;
    end
  end

  // Age matrix: older[i][j] means device i entered its queue before device j.
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_row
    for (genvar j = 0; j < NUM_DEV; j++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                older[i][j] <= 1'b0;
        else if (cap[i] && cap[j]) older[i][j] <= (i < j);
        else if (cap[j])           older[i][j] <= 1'b1;
        else if (cap[i])           older[i][j] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqd_head_sel.sv
module irqd_head_sel #(
  parameter int NUM_DEV = 8,
  parameter int CTX_W   = 1,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 9
) (
  input  logic [NUM_DEV-1:0]               pend,
  input  logic [NUM_DEV-1:0][CTX_W-1:0]    owner,
  input  logic [NUM_DEV-1:0][PRIO_W-1:0]   prio,
  input  logic [NUM_DEV-1:0][VEC_W-1:0]    vec,
  input  logic [NUM_DEV-1:0][NUM_DEV-1:0]  older,
  input  logic [CTX_W-1:0]                 ctx,
  output logic [NUM_DEV-1:0]               head_win,
  output logic [PRIO_W-1:0]                head_prio,
  output logic [VEC_W-1:0]                 head_vec
);
  import irqd_pkg::*;
  logic [NUM_DEV-1:0] cand;

  always_comb begin
    for (int i = 0; i < NUM_DEV; i++) cand[i] = pend[i] && (owner[i] == ctx);
    for (int i = 0; i < NUM_DEV; i++) begin
      head_win[i] = cand[i];
      for (int j = 0; j < NUM_DEV; j++) begin
        if (j != i && cand[j] &&
            !ranks_above(8'(prio[i]), 8'(prio[j]), older[i][j]))
          head_win[i] = 1'b0;
      end
    end
    head_prio = '0;
    head_vec  = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (head_win[i]) begin
        head_prio = prio[i];
        head_vec  = vec[i];
      end
    end
  end
endmodule

// File: rtl/irqd_service.sv
module irqd_service #(
  parameter int NUM_DEV = 8,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               blocked,
  input  logic               flag_act,
  input  logic               cmd_pending,
  input  logic [PRIO_W-1:0]  cpu_prio,
  input  logic [PRIO_W-1:0]  head_prio,
  input  logic [VEC_W-1:0]   head_vec,
  input  logic [NUM_DEV-1:0] head_win,
  output logic [NUM_DEV-1:0] remove,
  output logic               svc_trap,
  output logic [VEC_W-1:0]   svc_vec,
  output logic               svc_cmd,
  output logic               svc_resume
);
  import irqd_pkg::*;
  logic look, want_cmd, take;

  assign look     = boundary && !blocked;
  assign want_cmd = look && flag_act && cmd_pending;
  assign take     = look && flag_act && !cmd_pending &&
                    may_preempt(8'(cpu_prio), 8'(head_prio));
  assign remove   = take ? head_win : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_trap   <= 1'b0;
      svc_vec    <= '0;
      svc_cmd    <= 1'b0;
      svc_resume <= 1'b0;
    end else begin
      svc_trap   <= take;
      svc_vec    <= take ? head_vec : '0;
      svc_cmd    <= want_cmd;
      svc_resume <= look && !want_cmd && !take;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NUM_DEV = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 9,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [DEV_W-1:0]   cfg_dev,
  input  logic [CTX_W-1:0]   cfg_owner,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic [NUM_DEV-1:0] irq_req,
  output logic [NUM_DEV-1:0] irq_ack,
  input  logic [CTX_W-1:0]   act_ctx,
  input  logic               boundary,
  input  logic [PRIO_W-1:0]  cpu_prio,
  input  logic               cmd_pending,
  input  logic               wait_req,
  input  logic               ctx_reset_req,
  output logic [NUM_CTX-1:0] logical_flag,
  output logic [NUM_CTX-1:0] wait_flag,
  output logic               svc_trap,
  output logic [VEC_W-1:0]   svc_vec,
  output logic               svc_cmd,
  output logic               svc_resume,
  output logic [NUM_DEV-1:0] dev_init
);
  logic [NUM_DEV-1:0][CTX_W-1:0]   owner;
  logic [NUM_DEV-1:0][PRIO_W-1:0]  prio;
  logic [NUM_DEV-1:0][VEC_W-1:0]   vec;
  logic [NUM_DEV-1:0][NUM_DEV-1:0] older;
  logic [NUM_DEV-1:0] cap, pend, clr, remove, head_win, own_act;
  logic [PRIO_W-1:0]  head_prio;
  logic [VEC_W-1:0]   head_vec;
  logic [NUM_CTX-1:0] wake;
  logic               flag_act;

  irqd_dev_table #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .CTX_W(CTX_W),
                   .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .dev(cfg_dev),
    .owner_in(cfg_owner), .prio_in(cfg_prio), .vec_in(cfg_vec),
    .owner(owner), .prio(prio), .vec(vec));

  irqd_capture #(.NUM_DEV(NUM_DEV)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .clr(clr),
    .cap(cap), .pend(pend), .ack(irq_ack), .older(older));

  irqd_head_sel #(.NUM_DEV(NUM_DEV), .CTX_W(CTX_W), .PRIO_W(PRIO_W),
                  .VEC_W(VEC_W)) u_sel (
    .pend(pend), .owner(owner), .prio(prio), .vec(vec), .older(older),
    .ctx(act_ctx), .head_win(head_win), .head_prio(head_prio),
    .head_vec(head_vec));

  irqd_service #(.NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .blocked(ctx_reset_req),
    .flag_act(flag_act), .cmd_pending(cmd_pending), .cpu_prio(cpu_prio),
    .head_prio(head_prio), .head_vec(head_vec), .head_win(head_win),
    .remove(remove), .svc_trap(svc_trap), .svc_vec(svc_vec),
    .svc_cmd(svc_cmd), .svc_resume(svc_resume));

  always_comb begin
    logical_flag = '0;
    wake         = '0;
    flag_act     = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      own_act[i] = (owner[i] == act_ctx);
      for (int c = 0; c < NUM_CTX; c++) begin
        if (owner[i] == CTX_W'(c)) begin
          logical_flag[c] = logical_flag[c] | pend[i];
          wake[c]         = wake[c] | cap[i];
        end
      end
    end
    for (int c = 0; c < NUM_CTX; c++)
      if (act_ctx == CTX_W'(c)) flag_act = logical_flag[c];
  end

  assign clr = remove | (ctx_reset_req ? own_act : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_flag <= '0;
      dev_init  <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++)
        wait_flag[c] <= (wait_flag[c] | (wait_req && act_ctx == CTX_W'(c))) & ~wake[c];
      dev_init <= ctx_reset_req ? own_act : '0;
    end
  end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int NUM_DEV = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] irq_req,
  input logic [NUM_DEV-1:0] irq_ack,
  input logic               boundary,
  input logic               cmd_pending,
  input logic [PRIO_W-1:0]  cpu_prio,
  input logic [PRIO_W-1:0]  head_prio,
  input logic [NUM_DEV-1:0] remove,
  input logic               svc_trap,
  input logic               svc_cmd,
  input logic               svc_resume
);
  // R1: an acknowledge answers a request seen at the previous edge
  p_ack_answers_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack & ~$past(irq_req)) == '0);
  // R2: a held request is never acknowledged twice in a row
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack & $past(irq_ack)) == '0);
  // R4: any service outcome follows a boundary
  p_outcome_after_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_trap || svc_cmd || svc_resume) |-> $past(boundary));
  // R4: at most one outcome at a time
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({svc_trap, svc_cmd, svc_resume}) <= 1);
  // R5: a trap needs a strictly higher device priority
  p_trap_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_trap |-> $past(cpu_prio < head_prio));
  // R6: removal takes at most one queue entry per boundary
  p_remove_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(remove));
  // R7: a pending console command blocks the trap
  p_cmd_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_trap |-> !$past(cmd_pending));
endmodule

bind irq_dispatch irqd_checker #(.NUM_DEV(NUM_DEV), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .boundary(boundary), .cmd_pending(cmd_pending), .cpu_prio(cpu_prio),
  .head_prio(head_prio), .remove(remove), .svc_trap(svc_trap),
  .svc_cmd(svc_cmd), .svc_resume(svc_resume));

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int CLK_P   = 10;
  localparam int NUM_DEV = 6;
  localparam int NUM_CTX = 3;
  localparam int PRIO_W  = 3;
  localparam int VEC_W   = 9;
  localparam int DEV_W   = 3;
  localparam int CTX_W   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [DEV_W-1:0] cfg_dev = '0;
  logic [CTX_W-1:0] cfg_owner = '0;
  logic [PRIO_W-1:0] cfg_prio = '0;
  logic [VEC_W-1:0] cfg_vec = '0;
  logic [NUM_DEV-1:0] irq_req = '0, irq_ack, dev_init;
  logic [CTX_W-1:0] act_ctx = '0;
  logic boundary = 1'b0, cmd_pending = 1'b0, wait_req = 1'b0, ctx_reset_req = 1'b0;
  logic [PRIO_W-1:0] cpu_prio = '0;
  logic [NUM_CTX-1:0] logical_flag, wait_flag;
  logic svc_trap, svc_cmd, svc_resume;
  logic [VEC_W-1:0] svc_vec;

  int n_vec = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_dispatch #(.NUM_DEV(NUM_DEV), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_owner(cfg_owner),
    .cfg_prio(cfg_prio), .cfg_vec(cfg_vec), .irq_req(irq_req), .irq_ack(irq_ack),
    .act_ctx(act_ctx), .boundary(boundary), .cpu_prio(cpu_prio), .cmd_pending(cmd_pending),
    .wait_req(wait_req), .ctx_reset_req(ctx_reset_req), .logical_flag(logical_flag),
    .wait_flag(wait_flag), .svc_trap(svc_trap), .svc_vec(svc_vec), .svc_cmd(svc_cmd),
    .svc_resume(svc_resume), .dev_init(dev_init));

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int d, input int o, input int p, input int v);
    cfg_we = 1'b1; cfg_dev = DEV_W'(d); cfg_owner = CTX_W'(o);
    cfg_prio = PRIO_W'(p); cfg_vec = VEC_W'(v);
    step();
    cfg_we = 1'b0;
  endtask

  // Raise requests for one edge, check the acknowledge, drop them.
  task automatic raise(input logic [NUM_DEV-1:0] m, input string req);
    irq_req = m;
    step();
    check(req, "ack", 32'(irq_ack), 32'(m));
    irq_req = '0;
  endtask

  // One boundary; outcome code: 1 resume, 2 cmd, 3 trap.
  task automatic bnd(input int ctx, input int cpu, input logic cmd, input int exp_code,
                     input int exp_vec, input string req);
    int code;
    act_ctx = CTX_W'(ctx); cpu_prio = PRIO_W'(cpu); cmd_pending = cmd; boundary = 1'b1;
    step();
    boundary = 1'b0; cmd_pending = 1'b0;
    code = svc_trap ? 3 : svc_cmd ? 2 : svc_resume ? 1 : 0;
    check(req, "outcome", 32'(code), 32'(exp_code));
    check(req, "outcome count", 32'(svc_trap + svc_cmd + svc_resume), 32'd1);
    if (exp_code == 3) check(req, "vector", 32'(svc_vec), 32'(exp_vec));
    step();
    check(req, "outcome clears", 32'({svc_trap, svc_cmd, svc_resume}), 32'd0);
  endtask

  task automatic t_reset();
    check("R1", "reset ack", 32'(irq_ack), 0);
    check("R6", "reset flags", 32'(logical_flag), 0);
    check("R9", "reset wait", 32'(wait_flag), 0);
    check("R4", "reset outcome", 32'({svc_trap, svc_cmd, svc_resume}), 0);
  endtask

  task automatic t_capture();
    irq_req = 6'b000001;
    step();
    check("R1", "ack dev0", 32'(irq_ack), 32'b000001);
    check("R1", "flag ctx0", 32'(logical_flag), 32'b001);
    check("R4", "no boundary no outcome", 32'({svc_trap, svc_cmd, svc_resume}), 0);
    step();
    check("R2", "held request no re-ack", 32'(irq_ack), 0);
    irq_req = '0;
    step();
  endtask

  task automatic t_order();
    raise(6'b000100, "R3");
    raise(6'b000010, "R3");
    bnd(0, 5, 1'b0, 1, 0, "R5");         // equal priority: resume
    bnd(0, 0, 1'b0, 3, 'h044, "R3");     // highest priority first
    bnd(0, 0, 1'b0, 3, 'h040, "R3");     // equal priority: earlier capture
    bnd(0, 0, 1'b0, 3, 'h048, "R6");
    check("R6", "flag clears when empty", 32'(logical_flag), 0);
    bnd(0, 0, 1'b0, 1, 0, "R5");         // no logical interrupt: resume
    raise(6'b000101, "R3");
    bnd(0, 0, 1'b0, 3, 'h040, "R3");     // same-cycle: lower index first
    bnd(0, 0, 1'b0, 3, 'h048, "R3");
  endtask

  task automatic t_cmd();
    raise(6'b000001, "R7");
    bnd(0, 0, 1'b1, 2, 0, "R7");
    check("R7", "queue kept", 32'(logical_flag), 32'b001);
    bnd(0, 0, 1'b0, 3, 'h040, "R7");
  endtask

  task automatic t_inactive();
    act_ctx = 0;
    raise(6'b001000, "R8");
    bnd(0, 0, 1'b0, 1, 0, "R8");
    check("R8", "other ctx still pending", 32'(logical_flag), 32'b010);
    bnd(1, 0, 1'b0, 3, 'h050, "R8");
  endtask

  task automatic t_wait();
    act_ctx = 1; wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    check("R9", "wait set", 32'(wait_flag), 32'b010);
    raise(6'b100000, "R9");
    check("R9", "foreign device keeps wait", 32'(wait_flag), 32'b010);
    raise(6'b010000, "R9");
    check("R9", "own device releases wait", 32'(wait_flag), 0);
    bnd(1, 5, 1'b0, 3, 'h054, "R9");
    bnd(2, 0, 1'b0, 3, 'h058, "R9");
  endtask

  task automatic t_ctx_reset();
    raise(6'b001001, "R10");
    act_ctx = 0; ctx_reset_req = 1'b1; boundary = 1'b1;
    step();
    ctx_reset_req = 1'b0; boundary = 1'b0;
    check("R10", "init mask", 32'(dev_init), 32'b000111);
    check("R10", "no outcome", 32'({svc_trap, svc_cmd, svc_resume}), 0);
    check("R10", "own pending cleared", 32'(logical_flag), 32'b010);
    step();
    check("R10", "init pulse ends", 32'(dev_init), 0);
    bnd(1, 0, 1'b0, 3, 'h050, "R10");
  endtask

  task automatic t_owner();
    raise(6'b100000, "R11");
    check("R11", "flag ctx2", 32'(logical_flag), 32'b100);
    cfg(5, 0, 2, 'h058);
    check("R11", "moved to ctx0", 32'(logical_flag), 32'b001);
    bnd(0, 1, 1'b0, 3, 'h058, "R11");
    cfg(5, 2, 2, 'h058);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    cfg(0, 0, 3, 'h040);
    cfg(1, 0, 5, 'h044);
    cfg(2, 0, 3, 'h048);
    cfg(3, 1, 4, 'h050);
    cfg(4, 1, 6, 'h054);
    cfg(5, 2, 2, 'h058);
    t_capture();
    t_order();
    t_cmd();
    t_inactive();
    t_wait();
    t_ctx_reset();
    t_owner();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule